// File: doc/BRIEF.md
# Integer Execute Stage with Condition Flags

This block is the integer execute stage of a small 32-bit load/store processor. Each cycle in which `instr_valid` is high, it decodes one 32-bit instruction word. It reads its operands from an internal 32-entry register file and carries out one of the following:

- a three-register arithmetic or logic operation;
- an unsigned compare;
- a set-on-condition operation;
- an immediate move.

Results are written back into the register file at the clock edge. The same result is reported on a registered writeback port, so the rest of the pipeline can observe it.

A compare changes only two status bits, negative and zero. It writes no register. Separate set-on-condition instructions later copy a combination of those bits into a register as 0 or 1.

The stage also serves the memory, stack and sequencing blocks:

- It presents, without a register stage, the sign-extended 16-bit immediate of the current word.
- It presents the current contents of the two registers named by the word's first two register fields.
- It accepts the opcodes those blocks execute without acting on them.

It raises one-cycle trap pulses for two cases: an undefined opcode, and a divide or modulo whose divisor is zero.

Top module: `exu_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register, both flags and all registered outputs (`wb_en`, `wb_idx`, `wb_val`, `trap_ill`, `trap_dz`) become 0.
- R2: The word layout is opcode [31:26], ra [25:21], rb [20:16], rc [15:11], immediate [15:0]. Opcodes 0 to 6 (add, subtract, multiply low 32 bits, unsigned divide, unsigned modulo, AND, OR) write rb op rc into ra. The edge that accepts the word updates the register file, and after that edge `wb_en`=1, `wb_idx`=ra and `wb_val`=result.
- R3: Register 0 always reads as zero. A write addressed to it is shown on the writeback port but is not retained.
- R4: Opcode 3 or 4 with a zero rc value gives `trap_dz`=1 for one cycle and `wb_en`=0, and leaves ra unchanged.
- R5: Opcode 7 sets Z to (ra==rb) and N to (ra<rb, unsigned), and gives `wb_en`=0.
- R6: Opcodes 8 to 13 write 1 or 0 into ra. The value written is Z, !Z, N, Z|N, !N and !Z&!N respectively.
- R7: Opcode 14 writes the sign-extended immediate into ra. Values 0x8000 and above become negative.
- R8: `imm_ext` always equals the word's bit 15 repeated over bits 31:16, followed by bits 15:0, with no clock delay.
- R9: Opcodes 15 to 23 belong to other stages. They produce no writeback and no trap, and they leave the flags unchanged.
- R10: Opcodes 24 to 63 give `trap_ill`=1 for one cycle. They produce no writeback, and they leave registers and flags unchanged.
- R11: N and Z keep their values across every instruction other than opcode 7.
- R12: `rs_a_val` and `rs_b_val` show the current contents of registers ra and rb of the presented word, with no clock delay.
- R13: A cycle with `instr_valid` low changes no register or flag. After its edge, `wb_en`, `trap_ill` and `trap_dz` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is to be executed this cycle |
| instr | input | 32 | Instruction word |
| imm_ext | output | 32 | Sign-extended immediate of `instr` |
| rs_a_val | output | 32 | Contents of register ra |
| rs_b_val | output | 32 | Contents of register rb |
| wb_en | output | 1 | A register write happened at the last edge |
| wb_idx | output | 5 | Destination of that write |
| wb_val | output | 32 | Value of that write |
| flag_n | output | 1 | Negative (less-than) status bit |
| flag_z | output | 1 | Zero (equal) status bit |
| trap_ill | output | 1 | Illegal-opcode trap pulse |
| trap_dz | output | 1 | Divide-by-zero trap pulse |

## Verification
Results arrive at two latencies.

- `imm_ext`, `rs_a_val` and `rs_b_val` respond in the same cycle. The bench samples them one time step after it changes the word.
- The writeback port, both flags and both trap lines come from registers, so they are due after the single clock edge that accepts the word. The bench samples them at the falling edge that follows.

Each register write shows up in `rs_a_val` from the next cycle onward. The bench therefore checks the register file through that read port while it presents each later word.

The reference model updates its own register array and flags only once those comparisons are complete.

// File: rtl/exu_pkg.sv
// Shared opcode numbering, instruction field positions and decode classes
// of the execute stage. Assumes a fixed 32-bit word layout.
package exu_pkg;
    localparam int OPC_MSB = 31;
    localparam int OPC_LSB = 26;
    localparam int RA_LSB  = 21;
    localparam int RB_LSB  = 16;
    localparam int RC_LSB  = 11;
    localparam int IMM_W   = 16;
    localparam int OPC_W   = OPC_MSB - OPC_LSB + 1;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 6'd0,  OP_SUB  = 6'd1,  OP_MUL  = 6'd2,  OP_DIV = 6'd3,
        OP_MOD  = 6'd4,  OP_AND  = 6'd5,  OP_OR   = 6'd6,  OP_CMP = 6'd7,
        OP_SEQ  = 6'd8,  OP_SNE  = 6'd9,  OP_SLT  = 6'd10, OP_SLE = 6'd11,
        OP_SGE  = 6'd12, OP_SGT  = 6'd13, OP_MOVI = 6'd14, OP_LDW = 6'd15,
        OP_STW  = 6'd16, OP_PSH  = 6'd17, OP_POPR = 6'd18, OP_BRZ = 6'd19,
        OP_JMPR = 6'd20, OP_CAL  = 6'd21, OP_RTN  = 6'd22, OP_SYSC = 6'd23
    } opc_e;

    typedef enum logic [2:0] {
        CLS_ARITH, CLS_DIVIDE, CLS_COMPARE, CLS_SETCC, CLS_MOVE, CLS_OTHER, CLS_ILLEGAL
    } cls_e;
endpackage

// File: rtl/exu_decode.sv
// Splits an instruction word into opcode, register fields and the
// sign-extended immediate, and classifies the opcode. Pure combinational.
module exu_decode
    import exu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [31:0]      word,
    output logic [OPC_W-1:0] opc,
    output cls_e             cls,
    output logic [AW-1:0]    ra,
    output logic [AW-1:0]    rb,
    output logic [AW-1:0]    rc,
    output logic [XLEN-1:0]  imm
);
    // Field extraction and immediate sign extension
    always_comb begin
        opc = word[OPC_MSB:OPC_LSB];
        ra  = word[RA_LSB +: AW];
        rb  = word[RB_LSB +: AW];
        rc  = word[RC_LSB +: AW];
        imm = {{(XLEN-IMM_W){word[IMM_W-1]}}, word[IMM_W-1:0]};
    end

    // Opcode classification by group
    always_comb begin
        if (opc == OP_DIV || opc == OP_MOD)                      cls = CLS_DIVIDE;
        else if (opc <= OP_OR)                                   cls = CLS_ARITH;
        else if (opc == OP_CMP)                                  cls = CLS_COMPARE;
        else if (opc <= OP_SGT)                                  cls = CLS_SETCC;
        else if (opc == OP_MOVI)                                 cls = CLS_MOVE;
        else if (opc <= OP_SYSC)                                 cls = CLS_OTHER;
        else                                                     cls = CLS_ILLEGAL;
    end
endmodule

// File: rtl/exu_regfile.sv
// General register file: one write port, NRD combinational read ports.
// Entry 0 is never written and always reads zero. Sync active-low reset.
module exu_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [XLEN-1:0]          wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][XLEN-1:0] rdata
);
    logic [XLEN-1:0] mem [NREGS];

    // Storage update; writes to entry 0 are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (we && waddr != '0) begin
            mem[waddr] <= wdata;
        end
    end

    // One read mux per port, entry 0 forced to zero
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb rdata[p] = (raddr[p] == '0) ? '0 : mem[raddr[p]];
    end
endmodule

// File: rtl/exu_alu.sv
// Result, flag and trap logic for one instruction. Assumes unsigned
// divide/compare; multiply keeps the low XLEN bits. Pure combinational.
module exu_alu
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [OPC_W-1:0] opc,
    input  cls_e             cls,
    input  logic [XLEN-1:0]  va,
    input  logic [XLEN-1:0]  vb,
    input  logic [XLEN-1:0]  vc,
    input  logic [XLEN-1:0]  imm,
    input  logic             n_in,
    input  logic             z_in,
    output logic [XLEN-1:0]  res,
    output logic             wr,
    output logic             dz,
    output logic             ill,
    output logic             fl_we,
    output logic             n_out,
    output logic             z_out
);
    logic cond;

    // Condition bit chosen by the set-on-condition opcode
    always_comb begin
        case (opc)
            OP_SEQ:  cond = z_in;
            OP_SNE:  cond = !z_in;
            OP_SLT:  cond = n_in;
            OP_SLE:  cond = z_in | n_in;
            OP_SGE:  cond = !n_in;
            default: cond = !z_in & !n_in;
        endcase
    end

    // Result value, write enable and traps per class
    always_comb begin
        res   = '0;
        wr    = 1'b0;
        dz    = 1'b0;
        ill   = (cls == CLS_ILLEGAL);
        fl_we = (cls == CLS_COMPARE);
        n_out = va < vb;
        z_out = va == vb;
        case (cls)
            CLS_ARITH: begin
                wr = 1'b1;
                case (opc)
                    OP_ADD:  res = vb + vc;
                    OP_SUB:  res = vb - vc;
                    OP_MUL:  res = vb * vc;
                    OP_AND:  res = vb & vc;
                    default: res = vb | vc;
                endcase
            end
            CLS_DIVIDE: begin
                if (vc == '0) begin
                    dz = 1'b1;
                end else begin
                    wr  = 1'b1;
                    res = (opc == OP_DIV) ? vb / vc : vb % vc;
                end
            end
            CLS_SETCC: begin
                wr  = 1'b1;
                res = XLEN'(cond);
            end
            CLS_MOVE: begin
                wr  = 1'b1;
                res = imm;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exu_core.sv
// Execute stage top: decode, register file, ALU, status flags and the
// registered writeback/trap outputs. One instruction per valid cycle.
module exu_core
    import exu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    output logic [XLEN-1:0] imm_ext,
    output logic [XLEN-1:0] rs_a_val,
    output logic [XLEN-1:0] rs_b_val,
    output logic            wb_en,
    output logic [AW-1:0]   wb_idx,
    output logic [XLEN-1:0] wb_val,
    output logic            flag_n,
    output logic            flag_z,
    output logic            trap_ill,
    output logic            trap_dz
);
    logic [OPC_W-1:0]     opc;
    cls_e                 cls;
    logic [AW-1:0]        ra, rb, rc;
    logic [2:0][AW-1:0]   rd_addr;
    logic [2:0][XLEN-1:0] rd_data;
    logic [XLEN-1:0]      res;
    logic                 wr, dz, ill, fl_we, n_nx, z_nx, do_wr;

    exu_decode #(.XLEN(XLEN), .AW(AW)) u_dec (
        .word(instr), .opc(opc), .cls(cls), .ra(ra), .rb(rb), .rc(rc), .imm(imm_ext)
    );

    // Read-port address assignment: ra, rb, rc
    always_comb rd_addr = {rc, rb, ra};

    assign do_wr = instr_valid && wr;

    exu_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NRD(3)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(do_wr), .waddr(ra), .wdata(res),
        .raddr(rd_addr), .rdata(rd_data)
    );

    assign rs_a_val = rd_data[0];
    assign rs_b_val = rd_data[1];

    exu_alu #(.XLEN(XLEN)) u_alu (
        .opc(opc), .cls(cls), .va(rd_data[0]), .vb(rd_data[1]), .vc(rd_data[2]),
        .imm(imm_ext), .n_in(flag_n), .z_in(flag_z), .res(res), .wr(wr), .dz(dz),
        .ill(ill), .fl_we(fl_we), .n_out(n_nx), .z_out(z_nx)
    );

    // Status flags: only a valid compare updates them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else if (instr_valid && fl_we) begin
            flag_n <= n_nx;
            flag_z <= z_nx;
        end
    end

    // Registered writeback report and one-cycle trap pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en    <= 1'b0;
            wb_idx   <= '0;
            wb_val   <= '0;
            trap_ill <= 1'b0;
            trap_dz  <= 1'b0;
        end else begin
            wb_en    <= do_wr;
            wb_idx   <= do_wr ? ra  : '0;
            wb_val   <= do_wr ? res : '0;
            trap_ill <= instr_valid && ill;
            trap_dz  <= instr_valid && dz;
        end
    end
endmodule

// File: rtl/exu_core_chk.sv
// Protocol checks on the execute stage ports, attached by bind.
module exu_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [31:0] instr,
    input logic [31:0] rs_a_val,
    input logic        wb_en,
    input logic        flag_n,
    input logic        flag_z,
    input logic        trap_ill,
    input logic        trap_dz
);
    // R4
    dz_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_dz |-> !wb_en);

    // R10
    ill_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ill |-> (!wb_en && !trap_dz));

    // R5
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[31:26] == 6'd7) |=> !wb_en);

    // R11
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && instr[31:26] == 6'd7) |=> $stable({flag_n, flag_z}));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!wb_en && !trap_ill && !trap_dz));

    // R3
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[25:21] == 5'd0) |-> (rs_a_val == 32'd0));
endmodule

bind exu_core exu_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .rs_a_val(rs_a_val), .wb_en(wb_en), .flag_n(flag_n), .flag_z(flag_z),
    .trap_ill(trap_ill), .trap_dz(trap_dz)
);

// File: tb/exu_core_test.sv
// Self-checking bench with a behavioural reference model of the stage.
module exu_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] imm_ext, rs_a_val, rs_b_val, wb_val;
    logic        wb_en, flag_n, flag_z, trap_ill, trap_dz;
    logic [4:0]  wb_idx;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mdl [32];
    logic mn = 1'b0, mz = 1'b0;

    always #5 clk = ~clk;

    exu_core uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .imm_ext(imm_ext), .rs_a_val(rs_a_val), .rs_b_val(rs_b_val),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val), .flag_n(flag_n),
        .flag_z(flag_z), .trap_ill(trap_ill), .trap_dz(trap_dz)
    );

    task automatic cmp(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rrr(input int op, input int a, input int b, input int c);
        return {op[5:0], a[4:0], b[4:0], c[4:0], 11'd0};
    endfunction

    function automatic logic [31:0] rim(input int op, input int a, input logic [15:0] imm);
        return {op[5:0], a[4:0], 5'd0, imm};
    endfunction

    // One valid instruction; called at a falling edge, returns at a falling edge
    task automatic step(input logic [31:0] w, input string req);
        int op, a, b, c;
        logic [31:0] sx, vb, vc, r;
        logic e_wb, e_ill, e_dz, en, ez;
        op = int'(w[31:26]); a = int'(w[25:21]); b = int'(w[20:16]); c = int'(w[15:11]);
        sx = {{16{w[15]}}, w[15:0]};
        vb = mdl[b]; vc = mdl[c];
        e_wb = 0; e_ill = 0; e_dz = 0; en = mn; ez = mz; r = '0;
        instr = w; instr_valid = 1'b1;
        #1;
        cmp("R8", "imm_ext", imm_ext, sx);
        cmp("R12", "rs_a_val", rs_a_val, mdl[a]);
        cmp("R12", "rs_b_val", rs_b_val, mdl[b]);
        case (op)
            0: begin e_wb = 1; r = vb + vc; end
            1: begin e_wb = 1; r = vb - vc; end
            2: begin e_wb = 1; r = vb * vc; end
            3: if (vc == 0) e_dz = 1; else begin e_wb = 1; r = vb / vc; end
            4: if (vc == 0) e_dz = 1; else begin e_wb = 1; r = vb % vc; end
            5: begin e_wb = 1; r = vb & vc; end
            6: begin e_wb = 1; r = vb | vc; end
            7: begin en = mdl[a] < mdl[b]; ez = mdl[a] == mdl[b]; end
            8:  begin e_wb = 1; r = {31'd0, mz}; end
            9:  begin e_wb = 1; r = {31'd0, !mz}; end
            10: begin e_wb = 1; r = {31'd0, mn}; end
            11: begin e_wb = 1; r = {31'd0, mz | mn}; end
            12: begin e_wb = 1; r = {31'd0, !mn}; end
            13: begin e_wb = 1; r = {31'd0, !mz & !mn}; end
            14: begin e_wb = 1; r = sx; end
            default: if (op > 23) e_ill = 1;
        endcase
        @(posedge clk);
        #1 instr_valid = 1'b0;
        @(negedge clk);
        cmp(req, "wb_en", {31'd0, wb_en}, {31'd0, e_wb});
        if (e_wb) begin
            cmp(req, "wb_idx", {27'd0, wb_idx}, a[31:0]);
            cmp(req, "wb_val", wb_val, r);
        end
        cmp(req, "trap_ill", {31'd0, trap_ill}, {31'd0, e_ill});
        cmp(req, "trap_dz", {31'd0, trap_dz}, {31'd0, e_dz});
        cmp(req, "flag_n", {31'd0, flag_n}, {31'd0, en});
        cmp(req, "flag_z", {31'd0, flag_z}, {31'd0, ez});
        if (e_wb && a != 0) mdl[a] = r;
        mn = en; mz = ez;
    endtask

    // One idle cycle with a non-trivial word on the bus (R13)
    task automatic idle(input logic [31:0] w);
        instr = w; instr_valid = 1'b0;
        @(negedge clk);
        cmp("R13", "wb_en", {31'd0, wb_en}, 32'd0);
        cmp("R13", "trap_ill", {31'd0, trap_ill}, 32'd0);
        cmp("R13", "trap_dz", {31'd0, trap_dz}, 32'd0);
        cmp("R13", "flag_n", {31'd0, flag_n}, {31'd0, mn});
        cmp("R13", "flag_z", {31'd0, flag_z}, {31'd0, mz});
        #1;
        cmp("R13", "rs_a_val unchanged", rs_a_val, mdl[w[25:21]]);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        instr = rrr(0, 1, 2, 3);
        #1;
        cmp("R1", "wb_en", {31'd0, wb_en}, 32'd0);
        cmp("R1", "flags", {30'd0, flag_n, flag_z}, 32'd0);
        cmp("R1", "traps", {30'd0, trap_ill, trap_dz}, 32'd0);
        cmp("R1", "r1", rs_a_val, 32'd0);
        cmp("R1", "r2", rs_b_val, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: moves with positive and negative immediates
        step(rim(14, 1, 16'h0005), "R7");
        step(rim(14, 2, 16'hFFFE), "R7");
        step(rim(14, 3, 16'h7FFF), "R7");
        step(rim(14, 4, 16'h8000), "R7");
        step(rim(14, 9, 16'd77), "R7");
        // R3: write to r0 then read it back
        step(rim(14, 0, 16'd9), "R3");
        step(rrr(0, 5, 0, 1), "R3");
        // R2: three-register operations
        step(rrr(0, 10, 1, 2), "R2");
        step(rrr(1, 11, 1, 2), "R2");
        step(rrr(2, 12, 2, 3), "R2");
        step(rrr(3, 13, 2, 1), "R2");
        step(rrr(4, 14, 2, 1), "R2");
        step(rrr(5, 15, 2, 3), "R2");
        step(rrr(6, 16, 4, 1), "R2");
        step(rrr(3, 17, 1, 2), "R2");
        // R4: divide and modulo by zero keep r9
        step(rrr(3, 9, 1, 20), "R4");
        step(rrr(4, 9, 2, 0), "R4");
        step(rrr(0, 18, 9, 0), "R4");
        // R5/R6: three flag outcomes, each followed by all six set ops
        for (int k = 0; k < 3; k++) begin
            if (k == 0) step(rrr(7, 1, 2, 0), "R5");
            else if (k == 1) step(rrr(7, 1, 1, 0), "R5");
            else step(rrr(7, 2, 1, 0), "R5");
            for (int s = 8; s <= 13; s++) step(rrr(s, 20 + s - 8, 0, 0), "R6");
        end
        step(rrr(7, 1, 2, 0), "R5");
        // R11: flags kept over arithmetic and moves
        step(rrr(0, 26, 1, 1), "R11");
        step(rim(14, 27, 16'h1234), "R11");
        step(rrr(10, 28, 0, 0), "R11");
        // R9: opcodes of other stages
        for (int op = 15; op <= 23; op++) step(rrr(op, 1, 2, 3), "R9");
        // R10: undefined opcodes
        step(rrr(24, 1, 2, 3), "R10");
        step(rrr(40, 2, 1, 1), "R10");
        step(rrr(63, 3, 0, 0), "R10");
        step(rrr(7, 3, 3, 0), "R10");
        // R13: idle cycles with words that would write or trap
        idle(rim(14, 1, 16'hAAAA));
        idle(rrr(3, 1, 1, 0));
        idle(rrr(7, 2, 1, 0));
        step(rrr(0, 29, 1, 2), "R12");
        // R1: reset again clears registers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        mn = 1'b0; mz = 1'b0;
        step(rrr(0, 1, 2, 3), "R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule